// File: doc/BRIEF.md
# Paged Management Register Bank

This block is a 32-entry, 16-bit register space reached through a simple read/write management port, of the kind a transceiver exposes to its station manager. The lowest sixteen addresses are common to every page. Address 31 holds the page selector and sits outside every page. Addresses 16-21 and 23-28 are banked: each page has its own copy of them, and the page selector picks which copy the port reaches.

Individual bits behave according to an access attribute. Some are plain read/write. Some are status that hardware may overwrite. Some are read-only live values. Others are write-one-to-clear flags, self-clearing commands that hardware ends, latched-high events, latched-low conditions and clear-on-read flags. Reserved bits read as zero and ignore writes. Hardware event and status inputs feed the status bits, and completion inputs end commands.

Read effects run through a small access sequencer with two states. `S_IDLE` means no read-side effect is pending. `S_RELEASE` is the cycle in which the previous read's data is presented and its side effects are applied. The transitions are: `S_IDLE`→`S_RELEASE` on a read strobe, `S_RELEASE`→`S_RELEASE` on a back-to-back read strobe, `S_RELEASE`→`S_IDLE` when no read is strobed, and `S_IDLE`→`S_IDLE` otherwise.

Top module: `pgreg_bank`

## Requirements
- R1: Addresses 0-15 reach the same storage whatever the page. Addresses 5-15 are 16-bit read/write. Address 0 bits [15:8] are read/write control bits, also driven on `ctrl_bits`.
- R2: Address 31 is the page register and is reachable from every page. Only its low `PAGE_W` bits (2 by default) are stored, and they drive `page_sel`. All other bits read 0.
- R3: Addresses 16-21 and 23-28 are banked per page: a write lands in the bank of the current page, and a read returns that bank. Addresses 22, 29 and 30 read 0 and ignore writes.
- R4: A read strobe in cycle t presents its data on `mgmt_rdata` with `mgmt_rvalid` high one clock later. The data is the register's value before the strobe edge. `mgmt_rvalid` is low when no read was strobed in the previous cycle.
- R5: Address 1 bits [11:8] show `live_sts` as sampled at the read edge. Writes to address 1 have no effect. Reserved bits read 0: address 0 [7:2], address 1 [15:12], and addresses 2-4 [15:8].
- R6: Address 2 bits [7:0] are write-one-to-clear flags set by `flag_set`. A 1 written clears the bit and a 0 leaves it unchanged. A set arriving in the same cycle as a clear wins. Reads do not clear these bits.
- R7: Address 0 bits [1:0] are commands shown on `cmd_active`. Writing 1 starts a command and writing 0 has no effect. `cmd_done` clears the bit. A write of 1 in the same cycle as `cmd_done` keeps the bit set.
- R8: Address 1 bits [3:0] latch high on `evt_hi`. After a read they return to 0 unless the event is still present.
- R9: Address 1 bits [7:4] latch low when `lnk_lo` is low. After a read they show the live `lnk_lo` again.
- R10: Address 3 bits [7:0] are set by `cor_set`, cleared by a read, and ignore writes.
- R11: Address 4 bits [7:0] are read/write status. A `rws_load` pulse loads `rws_val`, and it overrides a software write in the same cycle.
- R12: Read side effects apply on the clock after data capture. An event sampled at the capture edge stays latched and is reported on the next read.
- R13: After reset every register reads 0, except the latched-low bits, which read 1 (address 1 reads 0x00F0 with `lnk_lo` high and `live_sts` zero), and page 0 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_rd | input | 1 | Read strobe |
| mgmt_wr | input | 1 | Write strobe |
| mgmt_addr | input | 5 | Register address |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data, one clock after the strobe |
| mgmt_rvalid | output | 1 | Read data valid |
| evt_hi | input | 4 | Events for the latched-high bits |
| lnk_lo | input | 4 | Live conditions for the latched-low bits |
| live_sts | input | 4 | Read-only live status |
| flag_set | input | 8 | Set pulses for write-one-to-clear flags |
| cor_set | input | 8 | Set pulses for clear-on-read flags |
| rws_load | input | 1 | Hardware load of the status field |
| rws_val | input | 8 | Value loaded by `rws_load` |
| cmd_done | input | 2 | Completion of the commands |
| cmd_active | output | 2 | Commands in progress |
| ctrl_bits | output | 8 | Read/write control bits |
| page_sel | output | PAGE_W | Current page |

## Verification
The embedded assertions check the following properties on every cycle:
- an event is latched on the very next clock, and a low condition is latched the same way;
- flag and clear-on-read sets always land;
- a command bit falls only together with its completion, and a hardware load always lands;
- the page changes only through a write to address 31;
- valid read data only follows a strobe and carries the sampled live status.

Other behaviours need the bench's scenarios, because they depend on what software saw:
- latch release after a read, and an event that coincides with a read;
- banking across all pages;
- the shared low range;
- writes being ignored;
- precedence between software writes and hardware actions.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;
    localparam int DW = 16;
    localparam int AW = 5;
    localparam int LH_W = 4;
    localparam int LL_W = 4;
    localparam int LIVE_W = 4;
    localparam int FLAG_W = 8;
    localparam int COR_W = 8;
    localparam int RWS_W = 8;
    localparam int SC_W = 2;
    localparam int CTRL_W = 8;
    localparam int BANK_SLOTS = 12;
    localparam int SCRATCH_N = 11;

    localparam logic [AW-1:0] A_CTRL    = 5'd0;
    localparam logic [AW-1:0] A_STAT    = 5'd1;
    localparam logic [AW-1:0] A_FLAG    = 5'd2;
    localparam logic [AW-1:0] A_COR     = 5'd3;
    localparam logic [AW-1:0] A_RWS     = 5'd4;
    localparam logic [AW-1:0] A_SCR_LO  = 5'd5;
    localparam logic [AW-1:0] A_SCR_HI  = 5'd15;
    localparam logic [AW-1:0] A_PAGE    = 5'd31;

    typedef enum logic [0:0] {S_IDLE, S_RELEASE} acc_state_t;

    function automatic logic is_banked(input logic [AW-1:0] a);
        return ((a >= 5'd16) && (a <= 5'd21)) || ((a >= 5'd23) && (a <= 5'd28));
    endfunction

    function automatic logic [3:0] bank_slot(input logic [AW-1:0] a);
        logic [AW-1:0] t;
        t = (a > 5'd21) ? (a - 5'd17) : (a - 5'd16);
        return t[3:0];
    endfunction
endpackage

// File: rtl/pgreg_access_fsm.sv
module pgreg_access_fsm
    import pgreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    output logic          rel_en,
    output logic [AW-1:0] rel_addr
);
    acc_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (rd) state_d = S_RELEASE;
            S_RELEASE: state_d = rd ? S_RELEASE : S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            rel_addr <= '0;
        end else begin
            state_q <= state_d;
            if (rd) rel_addr <= addr;
        end
    end

    always_comb begin
        unique case (state_q)
            S_RELEASE: rel_en = 1'b1;
            default:   rel_en = 1'b0;
        endcase
    end

    // R12: every captured read is followed by a release cycle
    assert_release_after_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rel_en);
endmodule

// File: rtl/pgreg_status_bits.sv
module pgreg_status_bits
    import pgreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic              rel_en,
    input  logic [AW-1:0]     rel_addr,
    input  logic [LH_W-1:0]   evt_hi,
    input  logic [LL_W-1:0]   lnk_lo,
    input  logic [FLAG_W-1:0] flag_set,
    input  logic [COR_W-1:0]  cor_set,
    input  logic              rws_load,
    input  logic [RWS_W-1:0]  rws_val,
    input  logic [SC_W-1:0]   cmd_done,
    output logic [LH_W-1:0]   lh_q,
    output logic [LL_W-1:0]   ll_q,
    output logic [FLAG_W-1:0] flag_q,
    output logic [COR_W-1:0]  cor_q,
    output logic [RWS_W-1:0]  rws_q,
    output logic [SC_W-1:0]   sc_q,
    output logic [CTRL_W-1:0] ctrl_q
);
    logic [LH_W-1:0]  lh_hold;
    logic [LL_W-1:0]  ll_hold;
    logic [COR_W-1:0] cor_hold;
    logic wr_ctrl, wr_flag, wr_rws, rel_stat, rel_cor;

    assign wr_ctrl  = wr && (addr == A_CTRL);
    assign wr_flag  = wr && (addr == A_FLAG);
    assign wr_rws   = wr && (addr == A_RWS);
    assign rel_stat = rel_en && (rel_addr == A_STAT);
    assign rel_cor  = rel_en && (rel_addr == A_COR);

    // events seen at the capture edge are not in the returned data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lh_hold  <= '0;
            ll_hold  <= '0;
            cor_hold <= '0;
        end else begin
            if (rd && addr == A_STAT) begin
                lh_hold <= evt_hi;
                ll_hold <= ~lnk_lo;
            end
            if (rd && addr == A_COR) cor_hold <= cor_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lh_q <= '0;
            ll_q <= '1;
            cor_q <= '0;
        end else begin
            lh_q  <= rel_stat ? (evt_hi | lh_hold) : (lh_q | evt_hi);
            ll_q  <= rel_stat ? (lnk_lo & ~ll_hold) : (ll_q & lnk_lo);
            cor_q <= rel_cor ? (cor_set | cor_hold) : (cor_q | cor_set);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            rws_q  <= '0;
            sc_q   <= '0;
            ctrl_q <= '0;
        end else begin
            flag_q <= (wr_flag ? (flag_q & ~wdata[FLAG_W-1:0]) : flag_q) | flag_set;
            if (rws_load)    rws_q <= rws_val;
            else if (wr_rws) rws_q <= wdata[RWS_W-1:0];
            sc_q <= (sc_q & ~cmd_done) | (wr_ctrl ? wdata[SC_W-1:0] : '0);
            if (wr_ctrl) ctrl_q <= wdata[DW-1:DW-CTRL_W];
        end
    end

    assert_event_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((lh_q & $past(evt_hi)) == $past(evt_hi)));
    assert_low_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((ll_q & ~$past(lnk_lo)) == '0));
    assert_flag_set_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flag_q & $past(flag_set)) == $past(flag_set)));
    assert_cor_set_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cor_q & $past(cor_set)) == $past(cor_set)));
    assert_cmd_ends_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((~sc_q & $past(sc_q) & ~$past(cmd_done)) == '0));
    assert_hw_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rws_load) |-> (rws_q == $past(rws_val)));
endmodule

// File: rtl/pgreg_page_store.sv
module pgreg_page_store
    import pgreg_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [PAGE_W-1:0] page_q,
    output logic [DW-1:0]     store_rdata
);
    logic [DW-1:0] scratch [SCRATCH_N];
    logic [DW-1:0] page_rd [NUM_PAGES];
    logic [3:0]    slot;
    int            scr_idx;

    assign slot    = bank_slot(addr);
    assign scr_idx = int'(addr) - int'(A_SCR_LO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            for (int i = 0; i < SCRATCH_N; i++) scratch[i] <= '0;
        end else if (wr) begin
            if (addr == A_PAGE) page_q <= wdata[PAGE_W-1:0];
            if (addr >= A_SCR_LO && addr <= A_SCR_HI) scratch[scr_idx] <= wdata;
        end
    end

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        logic [DW-1:0] regs [BANK_SLOTS];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < BANK_SLOTS; s++) regs[s] <= '0;
            end else if (wr && is_banked(addr) && page_q == PAGE_W'(p)) begin
                regs[slot] <= wdata;
            end
        end
        assign page_rd[p] = regs[slot];
    end

    always_comb begin
        store_rdata = '0;
        if (addr == A_PAGE)
            store_rdata = {{(DW-PAGE_W){1'b0}}, page_q};
        else if (addr >= A_SCR_LO && addr <= A_SCR_HI)
            store_rdata = scratch[scr_idx];
        else if (is_banked(addr) && int'(page_q) < NUM_PAGES)
            store_rdata = page_rd[page_q];
    end

    // R2: the page only moves through a write to address 31
    assert_page_only_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(wr && addr == A_PAGE) |-> $stable(page_q));
endmodule

// File: rtl/pgreg_bank.sv
module pgreg_bank
    import pgreg_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_rd,
    input  logic              mgmt_wr,
    input  logic [4:0]        mgmt_addr,
    input  logic [15:0]       mgmt_wdata,
    output logic [15:0]       mgmt_rdata,
    output logic              mgmt_rvalid,
    input  logic [3:0]        evt_hi,
    input  logic [3:0]        lnk_lo,
    input  logic [3:0]        live_sts,
    input  logic [7:0]        flag_set,
    input  logic [7:0]        cor_set,
    input  logic              rws_load,
    input  logic [7:0]        rws_val,
    input  logic [1:0]        cmd_done,
    output logic [1:0]        cmd_active,
    output logic [7:0]        ctrl_bits,
    output logic [PAGE_W-1:0] page_sel
);
    logic          rel_en;
    logic [AW-1:0] rel_addr;
    logic [LH_W-1:0]   lh_q;
    logic [LL_W-1:0]   ll_q;
    logic [FLAG_W-1:0] flag_q;
    logic [COR_W-1:0]  cor_q;
    logic [RWS_W-1:0]  rws_q;
    logic [DW-1:0]     store_rdata;
    logic [DW-1:0]     rd_mux;

    pgreg_access_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rd(mgmt_rd), .addr(mgmt_addr),
        .rel_en(rel_en), .rel_addr(rel_addr)
    );

    pgreg_status_bits u_status (
        .clk(clk), .rst_n(rst_n), .wr(mgmt_wr), .rd(mgmt_rd), .addr(mgmt_addr),
        .wdata(mgmt_wdata), .rel_en(rel_en), .rel_addr(rel_addr),
        .evt_hi(evt_hi), .lnk_lo(lnk_lo), .flag_set(flag_set), .cor_set(cor_set),
        .rws_load(rws_load), .rws_val(rws_val), .cmd_done(cmd_done),
        .lh_q(lh_q), .ll_q(ll_q), .flag_q(flag_q), .cor_q(cor_q), .rws_q(rws_q),
        .sc_q(cmd_active), .ctrl_q(ctrl_bits)
    );

    pgreg_page_store #(.NUM_PAGES(NUM_PAGES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr(mgmt_wr), .addr(mgmt_addr), .wdata(mgmt_wdata),
        .page_q(page_sel), .store_rdata(store_rdata)
    );

    always_comb begin
        unique case (mgmt_addr)
            A_CTRL:  rd_mux = {ctrl_bits, {(DW-CTRL_W-SC_W){1'b0}}, cmd_active};
            A_STAT:  rd_mux = {{(DW-LIVE_W-LL_W-LH_W){1'b0}}, live_sts, ll_q, lh_q};
            A_FLAG:  rd_mux = {{(DW-FLAG_W){1'b0}}, flag_q};
            A_COR:   rd_mux = {{(DW-COR_W){1'b0}}, cor_q};
            A_RWS:   rd_mux = {{(DW-RWS_W){1'b0}}, rws_q};
            default: rd_mux = store_rdata;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mgmt_rdata <= '0;
        else if (mgmt_rd) mgmt_rdata <= rd_mux;
    end

    assign mgmt_rvalid = rel_en;

    assert_valid_follows_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rvalid |-> $past(mgmt_rd));
    assert_live_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rvalid && $past(mgmt_addr == A_STAT) |->
        (mgmt_rdata[11:8] == $past(live_sts)) && (mgmt_rdata[15:12] == 4'h0));
endmodule

// File: tb/pgreg_bank_tb.sv
module pgreg_bank_tb;
    logic clk = 1'b0;
    logic rst_n;
    logic mgmt_rd, mgmt_wr, mgmt_rvalid, rws_load;
    logic [4:0] mgmt_addr;
    logic [15:0] mgmt_wdata, mgmt_rdata;
    logic [3:0] evt_hi, lnk_lo, live_sts;
    logic [7:0] flag_set, cor_set, rws_val, ctrl_bits;
    logic [1:0] cmd_done, cmd_active;
    logic [1:0] page_sel;
    int total = 0, bad = 0;
    bit finished = 0;
    logic [15:0] d;

    always #2 clk = ~clk;

    pgreg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .mgmt_rd(mgmt_rd), .mgmt_wr(mgmt_wr),
        .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata),
        .mgmt_rvalid(mgmt_rvalid), .evt_hi(evt_hi), .lnk_lo(lnk_lo), .live_sts(live_sts),
        .flag_set(flag_set), .cor_set(cor_set), .rws_load(rws_load), .rws_val(rws_val),
        .cmd_done(cmd_done), .cmd_active(cmd_active), .ctrl_bits(ctrl_bits),
        .page_sel(page_sel)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] v);
        mgmt_wr = 1'b1; mgmt_addr = a; mgmt_wdata = v;
        tick();
        mgmt_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [15:0] v);
        mgmt_rd = 1'b1; mgmt_addr = a;
        tick();
        mgmt_rd = 1'b0;
        v = mgmt_rdata;
    endtask

    function automatic logic [15:0] pat(input int p, input int a);
        return 16'h1357 ^ 16'(p << 12) ^ 16'(a << 4) ^ 16'(a * (p + 3));
    endfunction

    function automatic logic is_bank_addr(input int a);
        return (a >= 16 && a <= 21) || (a >= 23 && a <= 28);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mgmt_rd = 0; mgmt_wr = 0; mgmt_addr = '0; mgmt_wdata = '0;
        evt_hi = '0; lnk_lo = 4'hF; live_sts = '0; flag_set = '0; cor_set = '0;
        rws_load = 0; rws_val = '0; cmd_done = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // R13 reset values over the whole address space, R4 valid low at idle
        chk("R4 idle rvalid", 16'(mgmt_rvalid), 16'h0);
        chk("R13 page_sel", 16'(page_sel), 16'h0);
        for (int a = 0; a < 32; a++) begin
            rd_reg(5'(a), d);
            chk($sformatf("R13 reset addr %0d", a), d, (a == 1) ? 16'h00F0 : 16'h0);
        end
        tick();
        rd_reg(5'd1, d);
        chk("R4 rvalid after strobe", 16'(mgmt_rvalid), 16'h1);
        tick();
        chk("R4 rvalid dropped", 16'(mgmt_rvalid), 16'h0);

        // R2 page register width and reachability
        wr_reg(5'd31, 16'hFFFD);
        rd_reg(5'd31, d); chk("R2 page readback", d, 16'h0001);
        chk("R2 page_sel", 16'(page_sel), 16'h0001);

        // R3 banked sweep: fill every page, then read every page back
        for (int p = 0; p < 4; p++) begin
            wr_reg(5'd31, 16'(p));
            for (int a = 16; a < 31; a++) wr_reg(5'(a), is_bank_addr(a) ? pat(p, a) : 16'hFFFF);
        end
        for (int p = 3; p >= 0; p--) begin
            wr_reg(5'd31, 16'(p));
            rd_reg(5'd31, d); chk("R2 page reachable", d, 16'(p));
            for (int a = 16; a < 31; a++) begin
                rd_reg(5'(a), d);
                chk($sformatf("R3 page %0d addr %0d", p, a), d, is_bank_addr(a) ? pat(p, a) : 16'h0);
            end
        end

        // R1 shared range written from page 2, read from every page
        wr_reg(5'd31, 16'd2);
        for (int a = 5; a < 16; a++) wr_reg(5'(a), pat(7, a));
        for (int p = 0; p < 4; p++) begin
            wr_reg(5'd31, 16'(p));
            for (int a = 5; a < 16; a++) begin
                rd_reg(5'(a), d);
                chk($sformatf("R1 shared page %0d addr %0d", p, a), d, pat(7, a));
            end
        end
        wr_reg(5'd31, 16'd0);

        // R7 commands and R1 control bits; R5 reserved [7:2]
        wr_reg(5'd0, 16'hABFF);
        chk("R7 cmd start", 16'(cmd_active), 16'h3);
        chk("R1 ctrl_bits", 16'(ctrl_bits), 16'h00AB);
        rd_reg(5'd0, d); chk("R5 R7 addr0 read", d, 16'hAB03);
        cmd_done = 2'b01; tick(); cmd_done = '0;
        chk("R7 done clears bit0", 16'(cmd_active), 16'h2);
        wr_reg(5'd0, 16'hAB00);
        chk("R7 write 0 no effect", 16'(cmd_active), 16'h2);
        cmd_done = 2'b10; wr_reg(5'd0, 16'hAB02); cmd_done = '0;
        chk("R7 write 1 beats done", 16'(cmd_active), 16'h2);
        cmd_done = 2'b10; tick(); cmd_done = '0;
        rd_reg(5'd0, d); chk("R7 all done", d, 16'hAB00);
        cmd_done = 2'b11; tick(); cmd_done = '0;
        chk("R7 done while idle", 16'(cmd_active), 16'h0);

        // R8 latched-high
        evt_hi = 4'b0101; tick(); evt_hi = '0;
        rd_reg(5'd1, d); chk("R8 pulse latched", 16'(d[3:0]), 16'h5);
        tick();
        rd_reg(5'd1, d); chk("R8 released", 16'(d[3:0]), 16'h0);
        tick();
        evt_hi = 4'b0010; tick();
        rd_reg(5'd1, d); chk("R8 level first", 16'(d[3:0]), 16'h2);
        tick();
        rd_reg(5'd1, d); evt_hi = '0;
        chk("R8 still present", 16'(d[3:0]), 16'h2);
        tick();
        rd_reg(5'd1, d); chk("R12 level seen at capture kept", 16'(d[3:0]), 16'h2);
        tick();
        rd_reg(5'd1, d); chk("R8 level gone", 16'(d[3:0]), 16'h0);
        tick();
        evt_hi = 4'b1000; rd_reg(5'd1, d); evt_hi = '0;
        chk("R12 same-cycle event not in data", 16'(d[3:0]), 16'h0);
        tick();
        rd_reg(5'd1, d); chk("R12 same-cycle event reported", 16'(d[3:0]), 16'h8);
        tick();
        rd_reg(5'd1, d); chk("R12 then released", 16'(d[3:0]), 16'h0);
        tick();

        // R9 latched-low
        lnk_lo = 4'b1101; tick(); lnk_lo = 4'hF;
        rd_reg(5'd1, d); chk("R9 drop latched", 16'(d[7:4]), 16'hD);
        tick();
        rd_reg(5'd1, d); chk("R9 live again", 16'(d[7:4]), 16'hF);
        tick();
        lnk_lo = 4'b1011; tick();
        rd_reg(5'd1, d); chk("R9 held low", 16'(d[7:4]), 16'hB);
        tick();
        rd_reg(5'd1, d); lnk_lo = 4'hF;
        chk("R9 live low", 16'(d[7:4]), 16'hB);
        tick();
        rd_reg(5'd1, d); chk("R12 low at capture kept", 16'(d[7:4]), 16'hB);
        tick();
        rd_reg(5'd1, d); chk("R9 recovered", 16'(d[7:4]), 16'hF);
        tick();

        // R5 live read-only field, writes to address 1 ignored
        live_sts = 4'hA; evt_hi = 4'b0001; tick(); evt_hi = '0;
        wr_reg(5'd1, 16'hFFFF);
        rd_reg(5'd1, d); chk("R5 write ignored", d, 16'h0AF1);
        tick();
        live_sts = 4'h5;
        rd_reg(5'd1, d); chk("R5 live follows", d, 16'h05F0);

        // R6 write-one-to-clear
        flag_set = 8'h3C; tick(); flag_set = '0;
        rd_reg(5'd2, d); chk("R6 set", d, 16'h003C);
        rd_reg(5'd2, d); chk("R6 read does not clear", d, 16'h003C);
        wr_reg(5'd2, 16'h0014);
        rd_reg(5'd2, d); chk("R6 one clears", d, 16'h0028);
        wr_reg(5'd2, 16'h0000);
        rd_reg(5'd2, d); chk("R6 zero keeps", d, 16'h0028);
        flag_set = 8'h01; wr_reg(5'd2, 16'h0029); flag_set = '0;
        rd_reg(5'd2, d); chk("R6 set beats clear", d, 16'h0001);
        wr_reg(5'd2, 16'hFFFF);
        rd_reg(5'd2, d); chk("R6 all cleared", d, 16'h0000);

        // R10 clear-on-read
        cor_set = 8'h81; tick(); cor_set = '0;
        rd_reg(5'd3, d); chk("R10 set", d, 16'h0081);
        tick();
        rd_reg(5'd3, d); chk("R10 cleared by read", d, 16'h0000);
        cor_set = 8'h10; tick(); cor_set = '0;
        wr_reg(5'd3, 16'hFFFF);
        rd_reg(5'd3, d); chk("R10 write ignored", d, 16'h0010);
        tick();
        cor_set = 8'h02; rd_reg(5'd3, d); cor_set = '0;
        chk("R12 cor same-cycle not in data", d, 16'h0000);
        tick();
        rd_reg(5'd3, d); chk("R12 cor same-cycle kept", d, 16'h0002);
        tick();
        rd_reg(5'd3, d); chk("R10 cleared again", d, 16'h0000);

        // R11 read/write status
        wr_reg(5'd4, 16'h00C3);
        rd_reg(5'd4, d); chk("R11 sw write", d, 16'h00C3);
        rws_val = 8'h5A; rws_load = 1'b1; tick(); rws_load = 1'b0;
        rd_reg(5'd4, d); chk("R11 hw load", d, 16'h005A);
        rws_val = 8'h22; rws_load = 1'b1; wr_reg(5'd4, 16'h0011); rws_load = 1'b0;
        rd_reg(5'd4, d); chk("R11 hw beats sw", d, 16'h0022);
        wr_reg(5'd4, 16'hFF77);
        rd_reg(5'd4, d); chk("R5 R11 reserved upper", d, 16'h0077);

        tick();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule